// File: doc/BRIEF.md
# Dual-Channel Auto-Reload Down Timer

This peripheral holds two independent 16-bit down counters. Each counter has its own 16-bit reload value. Both channels share one 8-bit control and status register. The host reaches all of them one byte at a time over a plain 8-bit register bus. The bus has an address, write data, a combinational read-data return, a read strobe and a write strobe.

A fixed prescaler divides the system clock by 20 and produces a single count tick that both channels use. A channel with its run bit set decrements on every tick. When the counter steps from 1 down to 0, the channel raises its status flag. On the next tick the counter reloads from its reload register. Each channel drives an interrupt line that is high while its flag and its interrupt enable are both set.

Software acknowledges a flag with two reads: first the control register, then either byte of that channel's counter. The output-control bits are kept only so that software can read them back.

Top module: `reload_timer2`

## Requirements
- R1: After a synchronous reset, both counters and both reload registers read 0xFFFF, the control register reads 0x00 and both interrupt lines are low.
- R2: The prescaler runs freely from reset. A channel whose run bit is set decrements exactly once every 20 clock cycles.
- R3: On the tick where a running counter holds 0, it loads the value of its reload register. With reload value N, a full period is N+1 ticks.
- R4: Each channel counts only while its run bit is set: bit 0 for channel 0, bit 1 for channel 1. A stopped counter holds its value. Byte writes to a counter take effect only while that channel is stopped and are ignored while it runs.
- R5: A channel's flag is set on the tick where its counter steps from 1 to 0. The flag reads back as bit 6 for channel 0 and bit 7 for channel 1.
- R6: A flag clears only when a control-register read made while the flag is set is followed by a read of either byte of that same channel's counter. A counter read with no prior control read, or a read of the other channel's counter, leaves the flag set.
- R7: If the clearing counter read falls in the same cycle as a new 1-to-0 step, the flag stays set, and the pending acknowledge is used up.
- R8: The interrupt line `irq[i]` is high exactly while channel i's flag is set and its enable bit is set. The enable bit is bit 4 for channel 0 and bit 5 for channel 1.
- R9: Control bits 5..0 are written and read back as stored. Write data on bits 7 and 6 is ignored.
- R10: The address map is fixed. Channel 0 counter low/high is at 0x0C/0x0D and its reload low/high at 0x0E/0x0F. Control is at 0x10. Channel 1 uses 0x14..0x17 in the same order. `rdata` always shows the addressed register, and read side effects occur only on cycles with `rd_en` high.
- R11: The two channels are independent. Running, flagging or acknowledging one channel does not change the other's counter or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; enables read side effects |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 2 | Interrupt request per channel |

## Verification
The assertions assume a bus that never asserts `rd_en` and `wr_en` together, and that holds one address per cycle. The bench stays within this: every access lasts exactly one cycle, is driven on the falling edge and issues a single strobe.

The cycle-exact test of R7 relies on the period of the free-running prescaler. The bench first observes one counter transition. It then places the acknowledging read exactly 20 cycles later, so that the read lands on the terminal tick.

The bench observes counters without side effects by setting `addr` with no strobe. This keeps polling from consuming a pending acknowledge.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    localparam int NCH       = 2;
    localparam int BYTE_W    = 8;
    localparam int CH_STRIDE = 8;

    localparam logic [7:0] CTRL_OFS = 8'h10;
    localparam logic [7:0] CH0_OFS  = 8'h0C;

    // Control/status byte; field order fixes bit positions (flag1 at bit 7).
    typedef struct packed {
        logic [1:0] flag;
        logic [1:0] ie;
        logic [1:0] oc;
        logic [1:0] run;
    } ctrl_t;

    // Per-channel bus request decoded at the top.
    typedef struct packed {
        logic wr_cnt_lo;
        logic wr_cnt_hi;
        logic wr_rld_lo;
        logic wr_rld_hi;
        logic rd_cnt;
    } chan_req_t;

    function automatic logic [7:0] chan_base(input int idx);
        return 8'(int'(CH0_OFS) + idx * CH_STRIDE);
    endfunction

endpackage

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst)               pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    p_pre_range_r2: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);

endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
    import rtmr_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            run,
    input  logic [BW-1:0]   wdata,
    input  chan_req_t       req,
    input  logic            stat_rd,
    output logic [2*BW-1:0] cnt,
    output logic [2*BW-1:0] rld,
    output logic            flag
);
    localparam int CW = 2 * BW;

    logic [CW-1:0] cnt_q, rld_q;
    logic          flag_q, pend_q;
    logic          step, term;

    assign step = tick && run;
    assign term = step && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '1;
            rld_q  <= '1;
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (step) begin
                cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
            end else if (!run) begin
                if (req.wr_cnt_lo) cnt_q[BW-1:0]  <= wdata;
                if (req.wr_cnt_hi) cnt_q[CW-1:BW] <= wdata;
            end
            if (req.wr_rld_lo) rld_q[BW-1:0]  <= wdata;
            if (req.wr_rld_hi) rld_q[CW-1:BW] <= wdata;

            if (term)                      flag_q <= 1'b1;
            else if (pend_q && req.rd_cnt) flag_q <= 1'b0;

            if (req.rd_cnt)             pend_q <= 1'b0;
            else if (stat_rd && flag_q) pend_q <= 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign rld  = rld_q;
    assign flag = flag_q;

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == '0) |=> cnt_q == $past(rld_q));
    p_hold_run_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt_q));
    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        term |=> flag_q);
    p_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(term));
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(pend_q && req.rd_cnt)) |=> flag_q);
    p_pend_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(stat_rd));

endmodule

// File: rtl/reload_timer2.sv
module reload_timer2
    import rtmr_pkg::*;
#(
    parameter int PRESCALE = 20,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    irq
);
    localparam int CW = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic            tick;
    logic [NCH-1:0]  flag_v;
    logic [NCH-1:0]  ie_q, oc_q, run_q;
    logic [CW-1:0]   cnt_a [NCH];
    logic [CW-1:0]   rld_a [NCH];
    logic            ctrl_wr, ctrl_rd;
    ctrl_t           ctrl_view;

    assign ctrl_wr = wr_en && (addr == CTRL_A);
    assign ctrl_rd = rd_en && (addr == CTRL_A);

    rtmr_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    // Flag bits (7:6) are owned by the channels; only 5:0 are stored here.
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= '0;
            oc_q  <= '0;
            run_q <= '0;
        end else if (ctrl_wr) begin
            ie_q  <= wdata[5:4];
            oc_q  <= wdata[3:2];
            run_q <= wdata[1:0];
        end
    end

    assign ctrl_view = '{flag: flag_v, ie: ie_q, oc: oc_q, run: run_q};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(chan_base(g));
        chan_req_t req;

        assign req.wr_cnt_lo = wr_en && (addr == BASE);
        assign req.wr_cnt_hi = wr_en && (addr == BASE + ADDR_W'(1));
        assign req.wr_rld_lo = wr_en && (addr == BASE + ADDR_W'(2));
        assign req.wr_rld_hi = wr_en && (addr == BASE + ADDR_W'(3));
        assign req.rd_cnt    = rd_en && ((addr == BASE) ||
                                         (addr == BASE + ADDR_W'(1)));

        rtmr_channel #(.BW(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .run     (run_q[g]),
            .wdata   (wdata),
            .req     (req),
            .stat_rd (ctrl_rd),
            .cnt     (cnt_a[g]),
            .rld     (rld_a[g]),
            .flag    (flag_v[g])
        );

        assign irq[g] = flag_v[g] & ie_q[g];
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) rdata = ctrl_view;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(chan_base(i)))     rdata = cnt_a[i][DATA_W-1:0];
            if (addr == ADDR_W'(chan_base(i) + 1)) rdata = cnt_a[i][CW-1:DATA_W];
            if (addr == ADDR_W'(chan_base(i) + 2)) rdata = rld_a[i][DATA_W-1:0];
            if (addr == ADDR_W'(chan_base(i) + 3)) rdata = rld_a[i][CW-1:DATA_W];
        end
    end

    p_cfg_keep_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> ($stable(run_q) && $stable(ie_q) && $stable(oc_q)));
    p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[5:4] == 2'b00) |=> irq == '0);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

endmodule

// File: tb/tb_reload_timer2.sv
module tb_reload_timer2;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_C0L = 8'h0C, A_C0H = 8'h0D, A_R0L = 8'h0E, A_R0H = 8'h0F;
    localparam logic [7:0] A_CTL = 8'h10;
    localparam logic [7:0] A_C1L = 8'h14, A_C1H = 8'h15, A_R1L = 8'h16, A_R1H = 8'h17;

    always #10 clk = ~clk;

    reload_timer2 dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_flag(input int bitn, input int limit, output bit seen);
        logic [7:0] v;
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            peek(A_CTL, v);
            if (v[bitn]) begin seen = 1'b1; break; end
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        logic [7:0] regs [8] = '{A_C0L, A_C0H, A_R0L, A_R0H, A_C1L, A_C1H, A_R1L, A_R1H};
        for (int i = 0; i < 8; i++) begin
            peek(regs[i], v);
            check(v == 8'hFF, "R1 counter/reload reset", v, 8'hFF);
        end
        peek(A_CTL, v);
        check(v == 8'h00, "R1 control reset", v, 8'h00);
        check(irq == 2'b00, "R1 irq reset", irq, 0);
    endtask

    task automatic t_ctrl_bits;
        logic [7:0] v;
        bus_wr(A_CTL, 8'hFC);
        peek(A_CTL, v);
        check(v == 8'h3C, "R9 flag bits ignore write", v, 8'h3C);
        bus_wr(A_CTL, 8'hC0);
        peek(A_CTL, v);
        check(v == 8'h00, "R9 only bits 7:6 written", v, 8'h00);
        bus_wr(A_CTL, 8'h00);
    endtask

    task automatic t_addr_map;
        logic [7:0] v;
        logic [7:0] regs [8] = '{A_C0L, A_C0H, A_R0L, A_R0H, A_C1L, A_C1H, A_R1L, A_R1H};
        for (int i = 0; i < 8; i++) bus_wr(regs[i], 8'h11 * 8'(i + 1));
        for (int i = 0; i < 8; i++) begin
            peek(regs[i], v);
            check(v == 8'h11 * 8'(i + 1), "R10 address map", v, 8'h11 * (i + 1));
        end
    endtask

    task automatic t_prescale;
        logic [7:0] v0, v1;
        int n;
        bus_wr(A_C0H, 8'h01); bus_wr(A_C0L, 8'h00);
        bus_wr(A_R0H, 8'h01); bus_wr(A_R0L, 8'h00);
        peek(A_C0L, v0);
        bus_wr(A_CTL, 8'h01);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk); peek(A_C0L, v1);
            if (v1 != v0) break;
        end
        check(v1 == 8'hFF, "R2 first decrement", v1, 8'hFF);
        n = 0; v0 = v1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); n++; peek(A_C0L, v1);
            if (v1 != v0) break;
        end
        check(n == 20, "R2 tick spacing", n, 20);
        check(v1 == 8'hFE, "R2 decrement by one", v1, 8'hFE);
        bus_wr(A_CTL, 8'h00);
    endtask

    task automatic t_run_hold;
        logic [7:0] v, v2;
        bus_wr(A_C0H, 8'h80); bus_wr(A_C0L, 8'h05);
        bus_wr(A_CTL, 8'h01);
        bus_wr(A_C0H, 8'h12);
        peek(A_C0H, v);
        check(v == 8'h80, "R4 write ignored while running", v, 8'h80);
        bus_wr(A_CTL, 8'h00);
        peek(A_C0L, v);
        repeat (45) @(negedge clk);
        peek(A_C0L, v2);
        check(v2 == v, "R4 stopped counter holds", v2, v);
        bus_wr(A_C0L, 8'h5A);
        peek(A_C0L, v);
        check(v == 8'h5A, "R4 write taken while stopped", v, 8'h5A);
    endtask

    task automatic t_reload;
        logic [7:0] v, c, seq [4];
        int k;
        bus_wr(A_C0H, 8'h00); bus_wr(A_C0L, 8'h02);
        bus_wr(A_R0H, 8'h00); bus_wr(A_R0L, 8'h05);
        bus_wr(A_CTL, 8'h01);
        peek(A_C0L, v);
        k = 0;
        for (int i = 0; i < 120 && k < 4; i++) begin
            @(negedge clk); peek(A_C0L, c);
            if (c != v) begin
                seq[k] = c; v = c;
                peek(A_CTL, c);
                if (k == 0) check(c[6] == 1'b0, "R5 no flag at count 1", c, 8'h01);
                if (k == 1) check(c[6] == 1'b1, "R5 flag on reaching 0", c, 8'h41);
                k++;
            end
        end
        check(k == 4 && seq[0] == 8'h01 && seq[1] == 8'h00, "R3 count to zero", seq[1], 0);
        check(k == 4 && seq[2] == 8'h05, "R3 reload value", seq[2], 5);
        check(k == 4 && seq[3] == 8'h04, "R3 continue after reload", seq[3], 4);
        bus_wr(A_CTL, 8'h00);
    endtask

    task automatic t_irq;
        check(irq[0] == 1'b0, "R8 flag without enable", irq, 0);
        bus_wr(A_CTL, 8'h10);
        check(irq == 2'b01, "R8 irq with enable", irq, 1);
        bus_wr(A_CTL, 8'h00);
        check(irq == 2'b00, "R8 irq masked", irq, 0);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        bus_rd(A_C0L, v);
        peek(A_CTL, v);
        check(v[6] == 1'b1, "R6 data read alone keeps flag", v, 8'h40);
        bus_rd(A_CTL, v);
        bus_rd(A_C1L, v);
        peek(A_CTL, v);
        check(v[6] == 1'b1, "R6 other channel read keeps flag", v, 8'h40);
        bus_rd(A_C0H, v);
        peek(A_CTL, v);
        check(v[6] == 1'b0, "R6 acknowledge clears flag", v, 8'h00);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        bit seen;
        bus_wr(A_C0H, 8'h00); bus_wr(A_C0L, 8'h01);
        bus_wr(A_R0H, 8'h00); bus_wr(A_R0L, 8'h02);
        bus_wr(A_CTL, 8'h01);
        wait_flag(6, 60, seen);
        check(seen, "R7 first terminal count", seen, 1);
        bus_rd(A_CTL, v);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            peek(A_C0L, v);
            if (v == 8'h01) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check(seen, "R7 counter reached 1", v, 1);
        repeat (19) @(negedge clk);
        bus_rd(A_C0L, v);
        peek(A_C0L, v);
        check(v == 8'h00, "R7 read on terminal tick", v, 0);
        peek(A_CTL, v);
        check(v[6] == 1'b1, "R7 new terminal keeps flag", v, 8'h41);
        bus_wr(A_CTL, 8'h00);
        bus_rd(A_C0L, v);
        peek(A_CTL, v);
        check(v[6] == 1'b1, "R7 pending consumed", v, 8'h40);
        bus_rd(A_CTL, v);
        bus_rd(A_C0L, v);
    endtask

    task automatic t_indep;
        logic [7:0] v;
        bit seen;
        bus_wr(A_C0H, 8'h00); bus_wr(A_C0L, 8'h40);
        bus_wr(A_C1H, 8'h00); bus_wr(A_C1L, 8'h03);
        bus_wr(A_R1H, 8'h00); bus_wr(A_R1L, 8'h03);
        bus_wr(A_CTL, 8'h02);
        wait_flag(7, 100, seen);
        check(seen, "R11 channel 1 flags", seen, 1);
        peek(A_CTL, v);
        check(v[6] == 1'b0, "R11 channel 0 flag untouched", v, 8'h82);
        peek(A_C0L, v);
        check(v == 8'h40, "R11 channel 0 counter untouched", v, 8'h40);
        bus_wr(A_CTL, 8'h30);
        check(irq == 2'b10, "R8 R11 irq per channel", irq, 2);
        bus_wr(A_CTL, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_bits();
        t_addr_map();
        t_prescale();
        t_run_hold();
        t_reload();
        t_irq();
        t_clear();
        t_priority();
        t_indep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule